// File: doc/BRIEF.md
# Command-Channel FIFO with Tagged Replies

This block is a first-in first-out store that software-like agents reach through a single request channel instead of separate write and read strobes. Each request names an operation, carries a data word and carries the identity of the agent that sent it. The block answers every request with exactly one reply on a separate response channel. The reply names the kind of result and returns the sender's identity, so a shared upstream arbiter can route it back.

Requests that cannot be carried out are not dropped. A write into a full store gets an explicit "full" reply. A read from an empty store gets an explicit "empty" reply. Either agent may also ask for the full or empty flag without changing anything. The storage is a circular buffer of parameterised depth, and its read and write pointers wrap at that depth. Only one request is in flight at a time: a new request is refused until the previous reply has been taken.

Top module: `cmd_fifo`

## Requirements
- R1: After reset the store is empty and no reply is valid. An empty query then replies with flag 1 and a full query replies with flag 0.
- R2: Every reply carries on `rsp_id` the value of `req_id` that came with its request.
- R3: A push (opcode 0) into a non-full store saves the word. It replies with opcode 0, flag 0 and the saved word on `rsp_data`.
- R4: A push into a full store saves nothing. It replies with opcode 3 (full), flag 1 and data 0, and the stored contents are unchanged.
- R5: A pop (opcode 1) from a non-empty store replies with opcode 1, flag 0 and the oldest stored word, and it frees that entry.
- R6: A pop from an empty store changes nothing. It replies with opcode 2 (empty), flag 1 and data 0.
- R7: An empty query (opcode 2) replies with opcode 2 and the current empty flag. A full query (opcode 3) replies with opcode 3 and the current full flag. Both reply with data 0, and neither changes any state.
- R8: Both pointers wrap modulo DEPTH. The store reports full after exactly DEPTH more pushes than pops, and first-in first-out order holds across any number of wrap-arounds.
- R9: While a reply is pending, `req_ready` is low, the reply fields hold steady, and any request offered in that time is not taken. `req_ready` returns high in the cycle after the reply handshake.
- R10: Opcodes 4 to 7 are handled as an empty query. They reply with opcode 2 and the current empty flag, and they change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_op | input | 3 | Request opcode: 0 push, 1 pop, 2 empty query, 3 full query |
| req_data | input | DATA_W | Word to push |
| req_id | input | ID_W | Sender identity |
| rsp_valid | output | 1 | Reply pending |
| rsp_ready | input | 1 | Reply taken |
| rsp_op | output | 3 | Reply kind, same encoding as the request opcode |
| rsp_data | output | DATA_W | Pushed or popped word, otherwise 0 |
| rsp_flag | output | 1 | Status flag: refusal, or the queried flag |
| rsp_id | output | ID_W | Echo of the sender identity |

## Verification
The bench builds the block with DEPTH 3, DATA_W 8 and ID_W 2. Because 3 is not a power of two, the pointer wrap has to be done explicitly rather than by natural overflow. Such a small depth also lets a short run fill the store, overflow it, drain it and wrap both pointers many times over. The 2-bit identity field lets all four sender values appear within a few transactions, and a 3-bit opcode reaches every one of the unrecognised codes 4 to 7.

// File: rtl/cmd_fifo_pkg.sv
// Shared opcode encodings for the command-channel FIFO.
// The same 3-bit code is used for requests and for reply kinds.
package cmd_fifo_pkg;
    localparam int OP_W = 3;
    localparam logic [OP_W-1:0] OP_PUSH   = 3'd0;
    localparam logic [OP_W-1:0] OP_POP    = 3'd1;
    localparam logic [OP_W-1:0] OP_EMPTYQ = 3'd2;
    localparam logic [OP_W-1:0] OP_FULLQ  = 3'd3;
endpackage

// File: rtl/cmd_fifo_store.sv
// Circular buffer with wrapping pointers and registered full/empty flags.
// Assumes: DEPTH >= 1; the caller never raises wr_en when full, never raises
// rd_en when empty, and never raises both in the same cycle.
module cmd_fifo_store #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;

    // Next pointer values, wrapping at the last slot.
    always_comb begin
        wr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
        rd_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    end

    // Storage array write; contents need no reset.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    assign rd_data = mem[rd_ptr];

    // Pointer and flag update on accepted push or pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            full   <= 1'b0;
            empty  <= 1'b1;
        end else if (wr_en) begin
            wr_ptr <= wr_nxt;
            empty  <= 1'b0;
            full   <= (wr_nxt == rd_ptr);
        end else if (rd_en) begin
            rd_ptr <= rd_nxt;
            full   <= 1'b0;
            empty  <= (rd_nxt == wr_ptr);
        end
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);
    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);
    // R8
    full_from_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(wr_en));
    // R8
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
endmodule

// File: rtl/cmd_fifo_ctrl.sv
// Request decoder and reply register. Takes one request at a time, drives
// the store's write/read enables and holds the reply until it is taken.
// Assumes: full/empty/rd_data come from the store in the same cycle.
module cmd_fifo_ctrl
    import cmd_fifo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ID_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [OP_W-1:0]   req_op,
    input  logic [DATA_W-1:0] req_data,
    input  logic [ID_W-1:0]   req_id,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [OP_W-1:0]   rsp_op,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_flag,
    output logic [ID_W-1:0]   rsp_id,
    input  logic              full,
    input  logic              empty,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic              rd_en
);
    logic              fire;
    logic [OP_W-1:0]   nxt_op;
    logic [DATA_W-1:0] nxt_data;
    logic              nxt_flag;

    assign req_ready = !rsp_valid;
    assign fire      = req_valid && req_ready;

    // Decode the request into store enables and the reply contents.
    always_comb begin
        wr_en    = 1'b0;
        rd_en    = 1'b0;
        nxt_data = '0;
        case (req_op)
            OP_PUSH: begin
                if (full) begin
                    nxt_op   = OP_FULLQ;
                    nxt_flag = 1'b1;
                end else begin
                    wr_en    = fire;
                    nxt_op   = OP_PUSH;
                    nxt_flag = 1'b0;
                    nxt_data = req_data;
                end
            end
            OP_POP: begin
                if (empty) begin
                    nxt_op   = OP_EMPTYQ;
                    nxt_flag = 1'b1;
                end else begin
                    rd_en    = fire;
                    nxt_op   = OP_POP;
                    nxt_flag = 1'b0;
                    nxt_data = rd_data;
                end
            end
            OP_FULLQ: begin
                nxt_op   = OP_FULLQ;
                nxt_flag = full;
            end
            default: begin
                nxt_op   = OP_EMPTYQ;
                nxt_flag = empty;
            end
        endcase
    end

    // Reply register: load on accepted request, clear on reply handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_op    <= '0;
            rsp_data  <= '0;
            rsp_flag  <= 1'b0;
            rsp_id    <= '0;
        end else if (fire) begin
            rsp_valid <= 1'b1;
            rsp_op    <= nxt_op;
            rsp_data  <= nxt_data;
            rsp_flag  <= nxt_flag;
            rsp_id    <= req_id;
        end else if (rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end

    // R2
    id_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_valid && rsp_id == $past(req_id)));
    // R9
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_op)
            && $stable(rsp_data) && $stable(rsp_flag) && $stable(rsp_id)));
    // R9
    ready_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> req_ready);
    // R3
    push_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rsp_op == OP_PUSH && rsp_data == $past(req_data)));
endmodule

// File: rtl/cmd_fifo.sv
// Command-channel FIFO top: wires the request decoder to the circular store.
// Assumes: DEPTH >= 1; requests come from one upstream arbiter.
module cmd_fifo
    import cmd_fifo_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    parameter int ID_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [DATA_W-1:0] req_data,
    input  logic [ID_W-1:0]   req_id,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [2:0]        rsp_op,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_flag,
    output logic [ID_W-1:0]   rsp_id
);
    logic              wr_en, rd_en, full, empty;
    logic [DATA_W-1:0] rd_data;

    cmd_fifo_ctrl #(.DATA_W(DATA_W), .ID_W(ID_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_data(req_data), .req_id(req_id),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_op(rsp_op),
        .rsp_data(rsp_data), .rsp_flag(rsp_flag), .rsp_id(rsp_id),
        .full(full), .empty(empty), .rd_data(rd_data),
        .wr_en(wr_en), .rd_en(rd_en)
    );

    cmd_fifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_data(req_data), .rd_en(rd_en),
        .rd_data(rd_data), .full(full), .empty(empty)
    );
endmodule

// File: tb/sim_cmd_fifo.sv
module sim_cmd_fifo;
    localparam int DEPTH = 3;
    localparam int DW    = 8;
    localparam int IW    = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [2:0]    req_op = '0;
    logic [DW-1:0] req_data = '0;
    logic [IW-1:0] req_id = '0;
    logic          rsp_valid;
    logic          rsp_ready = 1'b0;
    logic [2:0]    rsp_op;
    logic [DW-1:0] rsp_data;
    logic          rsp_flag;
    logic [IW-1:0] rsp_id;

    int checks = 0;
    int errors = 0;
    bit busy_m = 1'b0;
    bit done = 1'b0;
    int q[$];

    always #10 clk = ~clk;

    cmd_fifo #(.DEPTH(DEPTH), .DATA_W(DW), .ID_W(IW)) u0 (.*);

    // Every-clock comparison of handshake state against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (req_ready !== !busy_m || rsp_valid !== busy_m) begin
                errors++;
                $display("FAIL R9 ready=%0b valid=%0b expected ready=%0b valid=%0b",
                         req_ready, rsp_valid, !busy_m, busy_m);
            end
        end
    end

    task automatic cmp(string tag, logic [2:0] eo, logic [DW-1:0] ed, logic ef,
                       logic [IW-1:0] ei);
        checks++;
        if (rsp_valid !== 1'b1 || rsp_op !== eo || rsp_data !== ed ||
            rsp_flag !== ef || rsp_id !== ei) begin
            errors++;
            $display("FAIL %s got v=%0b op=%0d d=%0d f=%0b id=%0d expected op=%0d d=%0d f=%0b id=%0d",
                     tag, rsp_valid, rsp_op, rsp_data, rsp_flag, rsp_id, eo, ed, ef, ei);
        end
    endtask

    // One transaction; hold keeps the reply pending, intrude offers a push meanwhile.
    task automatic xact(string tag, logic [2:0] op, logic [DW-1:0] d,
                        logic [IW-1:0] id, int hold, bit intrude);
        logic [2:0] eo; logic [DW-1:0] ed; logic ef;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_data = d; req_id = id;
        @(posedge clk); #1;
        req_valid = 1'b0; busy_m = 1'b1;
        ed = '0;
        case (op)
            3'd0: if (q.size() == DEPTH) begin eo = 3'd3; ef = 1'b1; end
                  else begin q.push_back(int'(d)); eo = 3'd0; ef = 1'b0; ed = d; end
            3'd1: if (q.size() == 0) begin eo = 3'd2; ef = 1'b1; end
                  else begin ed = DW'(q.pop_front()); eo = 3'd1; ef = 1'b0; end
            3'd3: begin eo = 3'd3; ef = (q.size() == DEPTH); end
            default: begin eo = 3'd2; ef = (q.size() == 0); end
        endcase
        @(negedge clk);
        cmp(tag, eo, ed, ef, id);
        for (int i = 0; i < hold; i++) begin
            if (intrude) begin
                req_valid = 1'b1; req_op = 3'd0; req_data = 8'hEE; req_id = ~id;
            end
            @(negedge clk);
            cmp("R9", eo, ed, ef, id);
        end
        rsp_ready = 1'b1;
        @(posedge clk); #1;
        rsp_ready = 1'b0; req_valid = 1'b0; busy_m = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
            errors++;
            $display("FAIL R1 valid=%0b ready=%0b expected 0 1", rsp_valid, req_ready);
        end
        xact("R1", 3'd2, 8'h00, 2'd0, 0, 0);
        xact("R1", 3'd3, 8'h00, 2'd1, 0, 0);
        xact("R6", 3'd1, 8'h00, 2'd2, 0, 0);
        xact("R3", 3'd0, 8'h11, 2'd0, 0, 0);
        xact("R2", 3'd0, 8'h22, 2'd3, 0, 0);
        xact("R7", 3'd2, 8'h55, 2'd1, 0, 0);
        xact("R3", 3'd0, 8'h33, 2'd2, 0, 0);
        xact("R7", 3'd3, 8'h00, 2'd3, 0, 0);
        xact("R4", 3'd0, 8'h44, 2'd1, 0, 0);
        xact("R5", 3'd1, 8'h00, 2'd0, 2, 0);
        xact("R9", 3'd1, 8'h00, 2'd1, 3, 1);
        xact("R5", 3'd1, 8'h00, 2'd2, 0, 0);
        xact("R6", 3'd1, 8'h00, 2'd3, 0, 0);
        for (int c = 4; c < 8; c++) xact("R10", 3'(c), 8'h77, 2'(c), 0, 0);
        xact("R10", 3'd0, 8'h5A, 2'd0, 0, 0);
        xact("R10", 3'd5, 8'h00, 2'd1, 0, 0);
        xact("R5", 3'd1, 8'h00, 2'd2, 0, 0);
        for (int k = 0; k < 40; k++) begin
            xact("R8", 3'd0, 8'(k * 7 + 1), 2'(k), 0, 0);
            if (k % 3 != 1) xact("R8", 3'd0, 8'(k * 5 + 3), 2'(k + 1), 0, 0);
            xact("R8", 3'd1, 8'h00, 2'(k + 2), k % 2, 0);
            if (k % 4 == 0) xact("R8", 3'd3, 8'h00, 2'(k), 0, 0);
        end
        for (int k = 0; k < DEPTH + 1; k++) xact("R8", 3'd1, 8'h00, 2'(k), 0, 0);
        xact("R8", 3'd2, 8'h00, 2'd0, 0, 0);
        finish_run();
    end
endmodule